// File: doc/BRIEF.md
# DMA Channel Register File

This block is the processor-side register store of a four-channel DMA controller. Software reaches it over an 8-bit port with a chip select, separate read and write strobes and a 4-bit register offset. Every channel keeps a 16-bit current address, a 16-bit current count, and base copies of both, so that a transfer can restart from where it was programmed. Because the port is eight bits wide and these registers are sixteen, a single byte pointer shared by all channels decides which half an access reaches. Software puts the pointer back to the low half by writing a dedicated offset.

The block also stores one 6-bit mode field per channel and a 5-bit command word, and drives all of these state values to the transfer engine as registered outputs. The engine writes back new current address and count values when a transfer step completes, and it can ask for a channel's current registers to be reloaded from its base copies. Bus cycle timing and transfer sequencing belong to other blocks.

Top module: `dma_regfile`

## Requirements
- R1: A synchronous active-high reset clears every current and base register, all mode fields, the command word (which leaves the controller enabled with fixed priority) and rdata, and points the byte pointer at the low byte.
- R2: A write to offset 2c (channel c address) or 2c+1 (channel c count), c = 0..3, loads the data byte into the same half of both the current and the base register of that channel: the low byte (bits 7:0) when the pointer is low, the high byte (bits 15:8) when it is high.
- R3: The byte pointer is shared by all channels and toggles after every read or write of offsets 00h to 07h.
- R4: A write to offset 0Ch returns the byte pointer to low whatever the data byte is, and changes no stored register.
- R5: A read of offsets 00h to 07h places on rdata, one clock after the strobe, the byte of the channel's current (not base) register that the pointer selects.
- R6: A read of offsets 08h to 0Fh returns 00h and leaves the byte pointer unchanged.
- R7: A write to offset 0Bh loads data bits 7:2 into the mode field of the channel given by data bits 1:0; the other channels' mode fields keep their values.
- R8: A write to offset 08h loads data bits 4:0 into the command word: bit 0 memory-to-memory enable, bit 1 channel 0 address hold, bit 2 controller disable, bit 3 compressed timing, bit 4 rotating priority (0 = fixed); data bits 7:5 are ignored.
- R9: When upd_en is high, upd_addr and upd_cnt are loaded into the current address and count of channel upd_ch at the next clock; the base registers are unchanged.
- R10: When rld_en is high, the current address and count of channel rld_ch are loaded from its base registers at the next clock; a reload takes priority over an engine update of the same channel.
- R11: When a processor write and an engine update or reload hit the same register in one cycle, the written byte takes the processor value and the other byte takes the engine value.
- R12: Writes to offsets 09h, 0Ah, 0Dh, 0Eh and 0Fh change no output and do not move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select, active high |
| rd_en | input | 1 | Read strobe, active high |
| wr_en | input | 1 | Write strobe, active high |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| upd_en | input | 1 | Engine update of current registers |
| upd_ch | input | 2 | Channel of the engine update |
| upd_addr | input | 16 | New current address |
| upd_cnt | input | 16 | New current count |
| rld_en | input | 1 | Reload current registers from base |
| rld_ch | input | 2 | Channel to reload |
| cur_addr_o | output | 64 | Current address of all channels, channel c in bits 16c+15:16c |
| cur_cnt_o | output | 64 | Current count of all channels, same packing |
| base_addr_o | output | 64 | Base address of all channels, same packing |
| base_cnt_o | output | 64 | Base count of all channels, same packing |
| mode_o | output | 24 | Mode fields, channel c in bits 6c+5:6c |
| m2m_en_o | output | 1 | Memory-to-memory enable |
| ch0_hold_o | output | 1 | Channel 0 address hold |
| ctrl_dis_o | output | 1 | Controller disable |
| fast_tim_o | output | 1 | Compressed timing |
| rot_pri_o | output | 1 | Rotating priority select |

## Verification
The main function is tried with a programmed sequence of low-then-high byte writes and readbacks across two channels, which tells the shared pointer apart from a per-register one, and with a pointer clear between accesses, which separates a clear from a plain toggle. Reads of write-only offsets set between channel reads show whether they wrongly move the pointer. Mode and command writes with all data bits set expose a wrong channel field or leaking reserved bits, and engine updates, reloads and same-cycle processor writes show which source wins each byte and that base copies stay untouched.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;

  localparam logic [3:0] OFS_CMD    = 4'h8;
  localparam logic [3:0] OFS_MODE   = 4'hB;
  localparam logic [3:0] OFS_PTRCLR = 4'hC;

  typedef struct packed {
    logic rot_pri;
    logic fast_tim;
    logic ctrl_dis;
    logic ch0_hold;
    logic m2m_en;
  } cmd_t;

  localparam int CMDW = $bits(cmd_t);

endpackage

// File: rtl/dmarf_decode.sv
module dmarf_decode #(
  parameter int NCH = 4,
  parameter int RAW = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs,
  input  logic                   rd_en,
  input  logic                   wr_en,
  input  logic [RAW-1:0]         addr,
  output logic                   ptr_hi,
  output logic [$clog2(NCH)-1:0] sel_ch,
  output logic                   sel_cnt,
  output logic                   chreg_wr,
  output logic                   chreg_rd,
  output logic                   any_rd,
  output logic                   cmd_wr,
  output logic                   mode_wr
);
  import dmarf_pkg::*;

  localparam int CHW = $clog2(NCH);
  localparam logic [RAW-1:0] CH_SPAN = RAW'(2 * NCH);

  logic wr_act, in_region, ptr_clr;

  assign wr_act    = cs && wr_en;
  assign any_rd    = cs && rd_en && !wr_en;
  assign in_region = addr < CH_SPAN;
  assign chreg_wr  = wr_act && in_region;
  assign chreg_rd  = any_rd && in_region;
  assign ptr_clr   = wr_act && (addr == OFS_PTRCLR);
  assign cmd_wr    = wr_act && (addr == OFS_CMD);
  assign mode_wr   = wr_act && (addr == OFS_MODE);
  assign sel_cnt   = addr[0];
  assign sel_ch    = addr[CHW:1];

  always_ff @(posedge clk) begin
    if (rst)                       ptr_hi <= 1'b0;
    else if (ptr_clr)              ptr_hi <= 1'b0;
    else if (chreg_wr || chreg_rd) ptr_hi <= ~ptr_hi;
  end

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ptr_clr |=> !ptr_hi); // R4
  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (chreg_wr || chreg_rd) |=> (ptr_hi != $past(ptr_hi))); // R3
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!chreg_wr && !chreg_rd && !ptr_clr) |=> $stable(ptr_hi)); // R6

endmodule

// File: rtl/dmarf_word.sv
module dmarf_word #(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr,
  input  logic          hi,
  input  logic [WW/2-1:0] wdata,
  input  logic          eng_en,
  input  logic [WW-1:0] eng_val,
  input  logic          rld_en,
  output logic [WW-1:0] cur,
  output logic [WW-1:0] base
);
  localparam int BW = WW / 2;

  logic [WW-1:0] cur_nxt;

  always_comb begin
    cur_nxt = cur;
    if (rld_en)      cur_nxt = base;
    else if (eng_en) cur_nxt = eng_val;
    if (cpu_wr) begin
      if (hi) cur_nxt[WW-1:BW] = wdata;
      else    cur_nxt[BW-1:0]  = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      base <= '0;
    end else begin
      cur <= cur_nxt;
      if (cpu_wr) begin
        if (hi) base[WW-1:BW] <= wdata;
        else    base[BW-1:0]  <= wdata;
      end
    end
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cpu_wr |=> $stable(base)); // R9
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (rld_en && !cpu_wr) |=> (cur == $past(base))); // R10
  AST_CPU_WINS_HI: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && hi) |=> (cur[WW-1:BW] == $past(wdata))); // R11
  AST_CPU_WINS_LO: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !hi) |=> (cur[BW-1:0] == $past(wdata))); // R11

endmodule

// File: rtl/dmarf_channel.sv
module dmarf_channel #(
  parameter int WW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_addr,
  input  logic            wr_cnt,
  input  logic            hi,
  input  logic [WW/2-1:0] wdata,
  input  logic            upd_en,
  input  logic [WW-1:0]   upd_addr,
  input  logic [WW-1:0]   upd_cnt,
  input  logic            rld_en,
  output logic [WW-1:0]   cur_addr,
  output logic [WW-1:0]   cur_cnt,
  output logic [WW-1:0]   base_addr,
  output logic [WW-1:0]   base_cnt
);

  dmarf_word #(.WW(WW)) u_addr (
    .clk(clk), .rst(rst), .cpu_wr(wr_addr), .hi(hi), .wdata(wdata),
    .eng_en(upd_en), .eng_val(upd_addr), .rld_en(rld_en),
    .cur(cur_addr), .base(base_addr)
  );

  dmarf_word #(.WW(WW)) u_cnt (
    .clk(clk), .rst(rst), .cpu_wr(wr_cnt), .hi(hi), .wdata(wdata),
    .eng_en(upd_en), .eng_val(upd_cnt), .rld_en(rld_en),
    .cur(cur_cnt), .base(base_cnt)
  );

  AST_ONE_REG_WR: assert property (@(posedge clk) disable iff (rst)
    !(wr_addr && wr_cnt)); // R2

endmodule

// File: rtl/dmarf_ctrl.sv
module dmarf_ctrl #(
  parameter int NCH  = 4,
  parameter int BUSW = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  cmd_wr,
  input  logic                                  mode_wr,
  input  logic [BUSW-1:0]                       wdata,
  output logic [NCH-1:0][BUSW-$clog2(NCH)-1:0]  mode_q,
  output dmarf_pkg::cmd_t                       cmd_q
);
  import dmarf_pkg::*;

  localparam int CHW = $clog2(NCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (cmd_wr) cmd_q <= cmd_t'(wdata[CMDW-1:0]);
      for (int i = 0; i < NCH; i++) begin
        if (mode_wr && (wdata[CHW-1:0] == CHW'(i)))
          mode_q[i] <= wdata[BUSW-1:CHW];
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_mode_chk
    AST_MODE_OTHERS: assert property (@(posedge clk) disable iff (rst)
      !(mode_wr && (wdata[CHW-1:0] == CHW'(g))) |=> $stable(mode_q[g])); // R7
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cmd_wr |=> $stable(cmd_q)); // R8

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH  = 4,
  parameter int WW   = 16,
  parameter int BUSW = 8,
  parameter int RAW  = 4,
  localparam int CHW = $clog2(NCH),
  localparam int MW  = BUSW - CHW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [RAW-1:0]    addr,
  input  logic [BUSW-1:0]   wdata,
  output logic [BUSW-1:0]   rdata,
  input  logic              upd_en,
  input  logic [CHW-1:0]    upd_ch,
  input  logic [WW-1:0]     upd_addr,
  input  logic [WW-1:0]     upd_cnt,
  input  logic              rld_en,
  input  logic [CHW-1:0]    rld_ch,
  output logic [NCH*WW-1:0] cur_addr_o,
  output logic [NCH*WW-1:0] cur_cnt_o,
  output logic [NCH*WW-1:0] base_addr_o,
  output logic [NCH*WW-1:0] base_cnt_o,
  output logic [NCH*MW-1:0] mode_o,
  output logic              m2m_en_o,
  output logic              ch0_hold_o,
  output logic              ctrl_dis_o,
  output logic              fast_tim_o,
  output logic              rot_pri_o
);
  import dmarf_pkg::*;

  logic           ptr_hi, sel_cnt, chreg_wr, chreg_rd, any_rd, cmd_wr, mode_wr;
  logic [CHW-1:0] sel_ch;
  logic [NCH-1:0][WW-1:0] cur_a, cur_c;
  logic [NCH-1:0][MW-1:0] mode_q;
  cmd_t           cmd_q;
  logic [WW-1:0]  rd_word;

  dmarf_decode #(.NCH(NCH), .RAW(RAW)) u_dec (
    .clk(clk), .rst(rst), .cs(cs), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .ptr_hi(ptr_hi), .sel_ch(sel_ch), .sel_cnt(sel_cnt),
    .chreg_wr(chreg_wr), .chreg_rd(chreg_rd), .any_rd(any_rd),
    .cmd_wr(cmd_wr), .mode_wr(mode_wr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = chreg_wr && (sel_ch == CHW'(c));
    dmarf_channel #(.WW(WW)) u_ch (
      .clk(clk), .rst(rst),
      .wr_addr(hit && !sel_cnt), .wr_cnt(hit && sel_cnt),
      .hi(ptr_hi), .wdata(wdata),
      .upd_en(upd_en && (upd_ch == CHW'(c))),
      .upd_addr(upd_addr), .upd_cnt(upd_cnt),
      .rld_en(rld_en && (rld_ch == CHW'(c))),
      .cur_addr(cur_a[c]), .cur_cnt(cur_c[c]),
      .base_addr(base_addr_o[c*WW +: WW]), .base_cnt(base_cnt_o[c*WW +: WW])
    );
    assign cur_addr_o[c*WW +: WW] = cur_a[c];
    assign cur_cnt_o[c*WW +: WW]  = cur_c[c];
    assign mode_o[c*MW +: MW]     = mode_q[c];
  end

  dmarf_ctrl #(.NCH(NCH), .BUSW(BUSW)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .mode_wr(mode_wr), .wdata(wdata),
    .mode_q(mode_q), .cmd_q(cmd_q)
  );

  assign m2m_en_o   = cmd_q.m2m_en;
  assign ch0_hold_o = cmd_q.ch0_hold;
  assign ctrl_dis_o = cmd_q.ctrl_dis;
  assign fast_tim_o = cmd_q.fast_tim;
  assign rot_pri_o  = cmd_q.rot_pri;

  assign rd_word = sel_cnt ? cur_c[sel_ch] : cur_a[sel_ch];

  always_ff @(posedge clk) begin
    if (rst)           rdata <= '0;
    else if (chreg_rd) rdata <= ptr_hi ? rd_word[WW-1:WW-BUSW] : rd_word[BUSW-1:0];
    else if (any_rd)   rdata <= '0;
  end

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (any_rd && !chreg_rd) |=> (rdata == '0)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !any_rd |=> $stable(rdata)); // R5

endmodule

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;

  localparam int NCH = 4;
  localparam int WW  = 16;
  localparam int MW  = 6;

  logic clk = 1'b0;
  logic rst, cs, rd_en, wr_en, upd_en, rld_en;
  logic [3:0]  addr;
  logic [7:0]  wdata, rdata;
  logic [1:0]  upd_ch, rld_ch;
  logic [15:0] upd_addr, upd_cnt;
  logic [NCH*WW-1:0] cur_addr_o, cur_cnt_o, base_addr_o, base_cnt_o;
  logic [NCH*MW-1:0] mode_o;
  logic m2m_en_o, ch0_hold_o, ctrl_dis_o, fast_tim_o, rot_pri_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  dma_regfile u_dut (
    .clk(clk), .rst(rst), .cs(cs), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .upd_en(upd_en), .upd_ch(upd_ch),
    .upd_addr(upd_addr), .upd_cnt(upd_cnt), .rld_en(rld_en), .rld_ch(rld_ch),
    .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o), .base_addr_o(base_addr_o),
    .base_cnt_o(base_cnt_o), .mode_o(mode_o), .m2m_en_o(m2m_en_o),
    .ch0_hold_o(ch0_hold_o), .ctrl_dis_o(ctrl_dis_o), .fast_tim_o(fast_tim_o),
    .rot_pri_o(rot_pri_o)
  );

  // vector: {op[1:0], addr[3:0], data[7:0], expect[7:0]}; op 1 = write, 2 = read and compare
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {2'd1, 4'hC, 8'h00, 8'h00},
    {2'd1, 4'h2, 8'h34, 8'h00},
    {2'd1, 4'h2, 8'h12, 8'h00},
    {2'd1, 4'h3, 8'hFF, 8'h00},
    {2'd1, 4'h3, 8'h00, 8'h00},
    {2'd2, 4'h2, 8'h00, 8'h34},
    {2'd2, 4'h2, 8'h00, 8'h12},
    {2'd2, 4'h3, 8'h00, 8'hFF},
    {2'd2, 4'h3, 8'h00, 8'h00},
    {2'd1, 4'h6, 8'hAA, 8'h00},
    {2'd2, 4'h0, 8'h00, 8'h00},
    {2'd2, 4'h6, 8'h00, 8'hAA},
    {2'd1, 4'hC, 8'h5A, 8'h00},
    {2'd2, 4'h6, 8'h00, 8'hAA},
    {2'd2, 4'h9, 8'h00, 8'h00},
    {2'd2, 4'h6, 8'h00, 8'h00}
  };

  function automatic logic [15:0] w16(input logic [NCH*WW-1:0] v, input int c);
    return v[c*WW +: WW];
  endfunction

  function automatic logic [5:0] m6(input logic [NCH*MW-1:0] v, input int c);
    return v[c*MW +: MW];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0;
  endtask

  task automatic cpu_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    cs = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] cmd_bits();
    return {27'd0, rot_pri_o, fast_tim_o, ctrl_dis_o, ch0_hold_o, m2m_en_o};
  endfunction

  initial begin
    logic [7:0] rb;
    rst = 1'b1; cs = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    upd_en = 1'b0; upd_ch = '0; upd_addr = '0; upd_cnt = '0; rld_en = 1'b0; rld_ch = '0;
    do_reset();

    // R1 reset state
    chk("R1 rdata", {24'd0, rdata}, 32'h0);
    chk("R1 cur_addr", {16'd0, w16(cur_addr_o, 2)}, 32'h0);
    chk("R1 base_cnt", {16'd0, w16(base_cnt_o, 3)}, 32'h0);
    chk("R1 modes", {8'd0, mode_o}, 32'h0);
    chk("R1 cmd enabled fixed", cmd_bits(), 32'h0);

    // R2 R3 R4 R5 R6 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21:20] == 2'd1) cpu_wr(VEC[i][19:16], VEC[i][15:8]);
      else begin
        cpu_rd(VEC[i][19:16], rb);
        chk($sformatf("R3 R4 R5 R6 vector %0d", i), {24'd0, rb}, {24'd0, VEC[i][7:0]});
      end
    end
    chk("R2 ch1 base addr", {16'd0, w16(base_addr_o, 1)}, 32'h1234);
    chk("R2 ch1 cur addr", {16'd0, w16(cur_addr_o, 1)}, 32'h1234);
    chk("R2 ch1 base cnt", {16'd0, w16(base_cnt_o, 1)}, 32'h00FF);
    chk("R2 ch3 base addr", {16'd0, w16(base_addr_o, 3)}, 32'h00AA);

    // R7 mode writes: 0xB6 -> ch2 gets 0x2D; 0x07 -> ch3 gets 0x01
    cpu_wr(4'hB, 8'hB6);
    chk("R7 ch2 mode", {26'd0, m6(mode_o, 2)}, 32'h2D);
    chk("R7 ch0 mode untouched", {26'd0, m6(mode_o, 0)}, 32'h0);
    cpu_wr(4'hB, 8'h07);
    chk("R7 ch3 mode", {26'd0, m6(mode_o, 3)}, 32'h01);
    chk("R7 ch2 mode kept", {26'd0, m6(mode_o, 2)}, 32'h2D);

    // R8 command: 0xF5 -> bits 4:0 = 10101
    cpu_wr(4'h8, 8'hF5);
    chk("R8 cmd bits", cmd_bits(), 32'h15);

    // R12 writes to unused offsets; pointer is low here
    cpu_wr(4'h9, 8'hFF); cpu_wr(4'hA, 8'hFF); cpu_wr(4'hD, 8'hFF);
    cpu_wr(4'hE, 8'hFF); cpu_wr(4'hF, 8'hFF);
    chk("R12 cmd kept", cmd_bits(), 32'h15);
    chk("R12 modes kept", {8'd0, mode_o}, {8'd0, 6'h01, 6'h2D, 6'h00, 6'h00});
    chk("R12 ch1 addr kept", {16'd0, w16(cur_addr_o, 1)}, 32'h1234);
    cpu_rd(4'h6, rb);
    chk("R12 pointer still low", {24'd0, rb}, 32'hAA);

    // R9 engine update of ch2
    @(negedge clk);
    upd_en = 1'b1; upd_ch = 2'd2; upd_addr = 16'hBEEF; upd_cnt = 16'h0102;
    @(negedge clk);
    upd_en = 1'b0;
    chk("R9 ch2 cur addr", {16'd0, w16(cur_addr_o, 2)}, 32'hBEEF);
    chk("R9 ch2 cur cnt", {16'd0, w16(cur_cnt_o, 2)}, 32'h0102);
    chk("R9 ch2 base addr", {16'd0, w16(base_addr_o, 2)}, 32'h0);
    chk("R9 ch1 untouched", {16'd0, w16(cur_addr_o, 1)}, 32'h1234);

    // R5 read returns current, not base
    cpu_wr(4'hC, 8'h00);
    cpu_rd(4'h4, rb);
    chk("R5 current byte", {24'd0, rb}, 32'hEF);

    // R10 reload ch2; reload beats update on ch1
    @(negedge clk);
    rld_en = 1'b1; rld_ch = 2'd2;
    @(negedge clk);
    rld_ch = 2'd1; upd_en = 1'b1; upd_ch = 2'd1; upd_addr = 16'h5555; upd_cnt = 16'h6666;
    chk("R10 ch2 reloaded", {16'd0, w16(cur_addr_o, 2)}, 32'h0);
    @(negedge clk);
    rld_en = 1'b0; upd_en = 1'b0;
    chk("R10 reload over update", {16'd0, w16(cur_addr_o, 1)}, 32'h1234);

    // R11 CPU low byte write with same-cycle engine update of ch0
    cpu_wr(4'hC, 8'h00);
    @(negedge clk);
    cs = 1'b1; wr_en = 1'b1; addr = 4'h0; wdata = 8'h77;
    upd_en = 1'b1; upd_ch = 2'd0; upd_addr = 16'hABCD; upd_cnt = 16'h0;
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0; upd_en = 1'b0;
    chk("R11 merged current", {16'd0, w16(cur_addr_o, 0)}, 32'hAB77);
    chk("R11 base low only", {16'd0, w16(base_addr_o, 0)}, 32'h0077);

    // R1 reset mid-run, pointer back to low
    do_reset();
    chk("R1 cmd after reset", cmd_bits(), 32'h0);
    chk("R1 modes after reset", {8'd0, mode_o}, 32'h0);
    cpu_wr(4'h0, 8'h11);
    chk("R1 pointer low", {16'd0, w16(cur_addr_o, 0)}, 32'h0011);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule